// File: doc/BRIEF.md
# Bidirectional GPIO Port with Register Access

This block is an 8-pin general-purpose I/O port that sits on a small CPU I/O bus. Three bus addresses reach it. An output latch holds the value that output pins drive. A direction register sets each pin to input or output. A read-only sampling address returns the levels the pads actually present. On an input pin, the latch bit has a second job: it turns the pad pull-up on. Single-bit set and clear strobes change one bit of the latch or of the direction register and leave every other bit alone. Firmware can therefore flip one pin without a read-modify-write race.

An external-memory enable input hands all pins to an alternate multiplexed address/data function. While it is high, the alternate function's value and output enable go to the pads, and the direction register is ignored. Pull-ups are on for every pin in that mode. The latch and direction register keep their contents, and the bus can still read and write them. A per-pin pad model turns register state into drive-value, output-enable and pull-up-enable outputs. Pad inputs pass through a two-stage synchronizer before the bus can read them.

Top module: `gpio_bank`

## Requirements
- R1: After reset the output latch and the direction register are both 0x00. Every pin is then an input with its pull-up off: padOe = 0x00 and padPullEn = 0x00.
- R2: A write (wrEn) to address 0x1B loads the output latch, and a write to 0x1A loads the direction register. With rdEn high, each address returns its stored value on rdata in the same cycle.
- R3: Address 0x19 is read-only. Neither a write nor a bit set/clear at 0x19 changes the latch or the direction register.
- R4: A read of 0x19 returns padIn as it was two rising clock edges earlier (two-stage synchronizer).
- R5: In normal mode, padOe[n] equals direction bit n, and padOut equals the output latch.
- R6: In normal mode, padPullEn[n] is 1 exactly when latch bit n is 1 and direction bit n is 0.
- R7: bitSet with addr 0x1B or 0x1A sets bit bitIdx of that register at the next edge. All other bits keep their values.
- R8: bitClr with addr 0x1B or 0x1A clears bit bitIdx of that register at the next edge. All other bits keep their values.
- R9: Priority within one cycle is wrEn first, then bitSet, then bitClr. A full write discards both strobes, and set beats clear.
- R10: While extMemEn is 1: every bit of padOe equals altOe, padOut equals altOut, and padPullEn is 0xFF, whatever the direction register holds. The stored registers are not changed.
- R11: rdata is 0x00 when rdEn is low or when addr is not 0x19, 0x1A or 0x1B. Writes and bit strobes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 6 | I/O bus address |
| wrEn | input | 1 | Full-byte write strobe |
| rdEn | input | 1 | Read enable for rdata |
| wdata | input | 8 | Write data |
| bitSet | input | 1 | Set one bit of the addressed register |
| bitClr | input | 1 | Clear one bit of the addressed register |
| bitIdx | input | 3 | Bit index for bitSet/bitClr |
| rdata | output | 8 | Combinational read data |
| extMemEn | input | 1 | Hands pins to the alternate address/data function |
| altOut | input | 8 | Alternate-function drive value |
| altOe | input | 1 | Alternate-function output enable (whole bus) |
| padIn | input | 8 | Levels observed at the pads |
| padOut | output | 8 | Pad drive value |
| padOe | output | 8 | Pad output enable per pin |
| padPullEn | output | 8 | Pad pull-up enable per pin |

## Verification
The bench uses the default parameters: eight pins, a two-stage synchronizer, and port addresses 0x19 to 0x1B. With these values every bit index of the 3-bit bitIdx names a real pin, so the set and clear strobes can reach both the top and bottom bits. The two-edge synchronizer latency is short enough to sample one read at a time: a stale value after zero edges and after one edge, then the new value after the second edge. The fixed addresses leave the unmapped space around the port open for checks that reads return zero and writes are ignored.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  // Strobes from bus decode to the register datapath
  typedef struct packed {
    logic latchLoad;
    logic latchSet;
    logic latchClr;
    logic dirLoad;
    logic dirSet;
    logic dirClr;
    logic rdLatch;
    logic rdDir;
    logic rdPin;
  } gpioStrb_t;

endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] LATCH_ADDR = 6'h1B,
  parameter logic [ADDR_W-1:0] DIR_ADDR = 6'h1A,
  parameter logic [ADDR_W-1:0] PIN_ADDR = 6'h19
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              bitSet,
  input  logic              bitClr,
  output gpioStrb_t         strb
);

  logic hitLatch;
  logic hitDir;
  logic hitPin;
  logic doSet;
  logic doClr;

  always_comb begin
    hitLatch = (addr == LATCH_ADDR);
    hitDir   = (addr == DIR_ADDR);
    hitPin   = (addr == PIN_ADDR);
    // Full write wins, then set, then clear
    doSet    = bitSet & ~wrEn;
    doClr    = bitClr & ~wrEn & ~bitSet;
  end

  always_comb begin
    strb.latchLoad = wrEn & hitLatch;
    strb.latchSet  = doSet & hitLatch;
    strb.latchClr  = doClr & hitLatch;
    strb.dirLoad   = wrEn & hitDir;
    strb.dirSet    = doSet & hitDir;
    strb.dirClr    = doClr & hitDir;
    strb.rdLatch   = rdEn & hitLatch;
    strb.rdDir     = rdEn & hitDir;
    strb.rdPin     = rdEn & hitPin;
  end

endmodule

// File: rtl/gpio_bank_reg.sv
module gpio_bank_reg #(
  parameter int WIDTH = 8,
  localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic             setBit,
  input  logic             clrBit,
  input  logic [WIDTH-1:0] wdata,
  input  logic [IDX_W-1:0] bitIdx,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] bitMask;
  logic [WIDTH-1:0] nextQ;

  always_comb begin
    bitMask = '0;
    bitMask[bitIdx] = 1'b1;
    nextQ = q;
    if (load)        nextQ = wdata;
    else if (setBit) nextQ = q | bitMask;
    else if (clrBit) nextQ = q & ~bitMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) q <= '0;
    else       q <= nextQ;
  end

endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int PIN_COUNT = 8,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W = (PIN_COUNT > 1) ? $clog2(PIN_COUNT) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  gpioStrb_t            strb,
  input  logic [PIN_COUNT-1:0] wdata,
  input  logic [IDX_W-1:0]     bitIdx,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] latchQ,
  output logic [PIN_COUNT-1:0] dirQ,
  output logic [PIN_COUNT-1:0] pinQ,
  output logic [PIN_COUNT-1:0] rdata
);

  gpio_bank_reg #(.WIDTH(PIN_COUNT)) u_latch (
    .clk(clk), .rstN(rstN),
    .load(strb.latchLoad), .setBit(strb.latchSet), .clrBit(strb.latchClr),
    .wdata(wdata), .bitIdx(bitIdx), .q(latchQ)
  );

  gpio_bank_reg #(.WIDTH(PIN_COUNT)) u_dir (
    .clk(clk), .rstN(rstN),
    .load(strb.dirLoad), .setBit(strb.dirSet), .clrBit(strb.dirClr),
    .wdata(wdata), .bitIdx(bitIdx), .q(dirQ)
  );

  // Input synchronizer chain
  logic [PIN_COUNT-1:0] syncQ [SYNC_STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
    end else begin
      syncQ[0] <= padIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
    end
  end

  assign pinQ = syncQ[SYNC_STAGES-1];

  always_comb begin
    rdata = ({PIN_COUNT{strb.rdLatch}} & latchQ)
          | ({PIN_COUNT{strb.rdDir}}   & dirQ)
          | ({PIN_COUNT{strb.rdPin}}   & pinQ);
  end

endmodule

// File: rtl/gpio_bank_pad.sv
module gpio_bank_pad #(
  parameter int PIN_COUNT = 8
) (
  input  logic [PIN_COUNT-1:0] latchQ,
  input  logic [PIN_COUNT-1:0] dirQ,
  input  logic                 altMode,
  input  logic [PIN_COUNT-1:0] altOut,
  input  logic                 altOe,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe,
  output logic [PIN_COUNT-1:0] padPullEn
);

  for (genvar n = 0; n < PIN_COUNT; n++) begin : g_pin
    always_comb begin
      if (altMode) begin
        padOut[n]    = altOut[n];
        padOe[n]     = altOe;
        padPullEn[n] = 1'b1;
      end else begin
        padOut[n]    = latchQ[n];
        padOe[n]     = dirQ[n];
        padPullEn[n] = latchQ[n] & ~dirQ[n];
      end
    end
  end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int PIN_COUNT = 8,
  parameter int ADDR_W = 6,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] LATCH_ADDR = 6'h1B,
  parameter logic [ADDR_W-1:0] DIR_ADDR = 6'h1A,
  parameter logic [ADDR_W-1:0] PIN_ADDR = 6'h19,
  localparam int IDX_W = (PIN_COUNT > 1) ? $clog2(PIN_COUNT) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [PIN_COUNT-1:0] wdata,
  input  logic                 bitSet,
  input  logic                 bitClr,
  input  logic [IDX_W-1:0]     bitIdx,
  output logic [PIN_COUNT-1:0] rdata,
  input  logic                 extMemEn,
  input  logic [PIN_COUNT-1:0] altOut,
  input  logic                 altOe,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe,
  output logic [PIN_COUNT-1:0] padPullEn
);

  gpioStrb_t            strb;
  logic [PIN_COUNT-1:0] latchQ;
  logic [PIN_COUNT-1:0] dirQ;
  logic [PIN_COUNT-1:0] pinQ;

  gpio_bank_ctrl #(
    .ADDR_W(ADDR_W), .LATCH_ADDR(LATCH_ADDR),
    .DIR_ADDR(DIR_ADDR), .PIN_ADDR(PIN_ADDR)
  ) u_ctrl (
    .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .bitSet(bitSet), .bitClr(bitClr), .strb(strb)
  );

  gpio_bank_dp #(
    .PIN_COUNT(PIN_COUNT), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(wdata), .bitIdx(bitIdx),
    .padIn(padIn), .latchQ(latchQ), .dirQ(dirQ), .pinQ(pinQ), .rdata(rdata)
  );

  gpio_bank_pad #(.PIN_COUNT(PIN_COUNT)) u_pad (
    .latchQ(latchQ), .dirQ(dirQ), .altMode(extMemEn),
    .altOut(altOut), .altOe(altOe),
    .padOut(padOut), .padOe(padOe), .padPullEn(padPullEn)
  );

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int PIN_COUNT = 8,
  parameter int ADDR_W = 6,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] LATCH_ADDR = 6'h1B,
  parameter logic [ADDR_W-1:0] DIR_ADDR = 6'h1A,
  parameter logic [ADDR_W-1:0] PIN_ADDR = 6'h19,
  localparam int IDX_W = (PIN_COUNT > 1) ? $clog2(PIN_COUNT) : 1
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    addr,
  input logic                 wrEn,
  input logic                 rdEn,
  input logic [PIN_COUNT-1:0] wdata,
  input logic                 bitSet,
  input logic [IDX_W-1:0]     bitIdx,
  input logic [PIN_COUNT-1:0] rdata,
  input logic                 extMemEn,
  input logic [PIN_COUNT-1:0] altOut,
  input logic                 altOe,
  input logic [PIN_COUNT-1:0] padIn,
  input logic [PIN_COUNT-1:0] padOut,
  input logic [PIN_COUNT-1:0] padOe,
  input logic [PIN_COUNT-1:0] padPullEn,
  input logic [PIN_COUNT-1:0] latchQ,
  input logic [PIN_COUNT-1:0] dirQ,
  input logic [PIN_COUNT-1:0] pinQ
);

  // Edges seen since reset release, saturating
  logic [2:0] edgeCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               edgeCnt <= '0;
    else if (edgeCnt != 3'd7) edgeCnt <= edgeCnt + 3'd1;
  end

  logic mapped;
  assign mapped = (addr == LATCH_ADDR) || (addr == DIR_ADDR) || (addr == PIN_ADDR);

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rstN)
    (edgeCnt == 3'd0) |-> (latchQ == '0 && dirQ == '0));

  a_r3_pin_addr_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (addr == PIN_ADDR) |=> ($stable(latchQ) && $stable(dirQ)));

  if (SYNC_STAGES == 2) begin : g_syncChk
    a_r4_sync_latency: assert property (@(posedge clk) disable iff (!rstN)
      (edgeCnt >= 3'd2) |-> (pinQ == $past(padIn, 2)));
  end

  a_r5_oe_follows_dir: assert property (@(posedge clk) disable iff (!rstN)
    !extMemEn |-> (padOe == dirQ && padOut == latchQ));

  a_r6_pull_rule: assert property (@(posedge clk) disable iff (!rstN)
    !extMemEn |-> (padPullEn == (latchQ & ~dirQ)));

  a_r7_single_bit_set: assert property (@(posedge clk) disable iff (!rstN)
    (bitSet && !wrEn && addr == LATCH_ADDR) |=>
      (latchQ[$past(bitIdx)] && $onehot0(latchQ ^ $past(latchQ))));

  a_r9_write_wins: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == LATCH_ADDR) |=> (latchQ == $past(wdata)));

  a_r10_alt_override: assert property (@(posedge clk) disable iff (!rstN)
    extMemEn |-> (padOe == {PIN_COUNT{altOe}} && padOut == altOut && (&padPullEn)));

  a_r11_unmapped_no_write: assert property (@(posedge clk) disable iff (!rstN)
    !mapped |=> ($stable(latchQ) && $stable(dirQ)));

  a_r11_read_gate: assert property (@(posedge clk) disable iff (!rstN)
    (!rdEn || !mapped) |-> (rdata == '0));

endmodule

bind gpio_bank gpio_bank_chk #(
  .PIN_COUNT(PIN_COUNT), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES),
  .LATCH_ADDR(LATCH_ADDR), .DIR_ADDR(DIR_ADDR), .PIN_ADDR(PIN_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
  .wdata(wdata), .bitSet(bitSet), .bitIdx(bitIdx), .rdata(rdata),
  .extMemEn(extMemEn), .altOut(altOut), .altOe(altOe), .padIn(padIn),
  .padOut(padOut), .padOe(padOe), .padPullEn(padPullEn),
  .latchQ(latchQ), .dirQ(dirQ), .pinQ(pinQ)
);

// File: tb/gpio_bank_bench.sv
`timescale 1ns/1ps
module gpio_bank_bench;

  localparam logic [5:0] A_LATCH = 6'h1B;
  localparam logic [5:0] A_DIR   = 6'h1A;
  localparam logic [5:0] A_PIN   = 6'h19;
  localparam int SEL_RD = 0, SEL_OE = 1, SEL_OUT = 2, SEL_PU = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] addr = '0;
  logic       wrEn = 1'b0, rdEn = 1'b0, bitSet = 1'b0, bitClr = 1'b0;
  logic [7:0] wdata = '0;
  logic [2:0] bitIdx = '0;
  logic [7:0] rdata;
  logic       extMemEn = 1'b0, altOe = 1'b0;
  logic [7:0] altOut = '0, padIn = '0;
  logic [7:0] padOut, padOe, padPullEn;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  int         selQ[$];
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #2.5 clk = ~clk;

  gpio_bank u_gpio_bank (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wdata(wdata), .bitSet(bitSet), .bitClr(bitClr), .bitIdx(bitIdx),
    .rdata(rdata), .extMemEn(extMemEn), .altOut(altOut), .altOe(altOe),
    .padIn(padIn), .padOut(padOut), .padOe(padOe), .padPullEn(padPullEn)
  );

  // Monitor: pops expected items at the falling edge and compares
  always @(negedge clk) begin
    while (selQ.size() > 0) begin
      int         sel;
      logic [7:0] exp;
      logic [7:0] act;
      string      tag;
      sel = selQ.pop_front();
      exp = expQ.pop_front();
      tag = tagQ.pop_front();
      case (sel)
        SEL_RD:  act = rdata;
        SEL_OE:  act = padOe;
        SEL_OUT: act = padOut;
        default: act = padPullEn;
      endcase
      checks++;
      if (act !== exp) begin
        failures++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", tag, sel, act, exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expectOut(int sel, logic [7:0] v, string tag);
    selQ.push_back(sel);
    expQ.push_back(v);
    tagQ.push_back(tag);
  endtask

  task automatic busWr(logic [5:0] a, logic [7:0] d);
    addr = a; wdata = d; wrEn = 1'b1;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic rdChk(logic [5:0] a, logic [7:0] exp, string tag);
    addr = a; rdEn = 1'b1;
    expectOut(SEL_RD, exp, tag);
    tick();
    rdEn = 1'b0;
  endtask

  task automatic bitOp(logic [5:0] a, logic [2:0] idx, logic s, logic c);
    addr = a; bitIdx = idx; bitSet = s; bitClr = c;
    tick();
    bitSet = 1'b0; bitClr = 1'b0;
  endtask

  task automatic padChk(logic [7:0] oe, logic [7:0] outv, logic [7:0] pu, string tag);
    expectOut(SEL_OE, oe, tag);
    expectOut(SEL_OUT, outv, tag);
    expectOut(SEL_PU, pu, tag);
    tick();
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();

    // R1 reset state
    padChk(8'h00, 8'h00, 8'h00, "R1 pads after reset");
    rdChk(A_LATCH, 8'h00, "R1 latch reset");
    rdChk(A_DIR, 8'h00, "R1 dir reset");

    // R2, R5, R6 full writes
    busWr(A_LATCH, 8'hA5);
    rdChk(A_LATCH, 8'hA5, "R2 latch readback");
    padChk(8'h00, 8'hA5, 8'hA5, "R6 all inputs pull from latch");
    busWr(A_DIR, 8'h0F);
    rdChk(A_DIR, 8'h0F, "R2 dir readback");
    padChk(8'h0F, 8'hA5, 8'hA0, "R5 R6 mixed directions");

    // R3 pin address is read-only
    busWr(A_PIN, 8'hFF);
    bitOp(A_PIN, 3'd1, 1'b1, 1'b0);
    rdChk(A_LATCH, 8'hA5, "R3 latch after pin write");
    rdChk(A_DIR, 8'h0F, "R3 dir after pin write");

    // R4 synchronizer latency
    padIn = 8'h3C;
    rdChk(A_PIN, 8'h00, "R4 zero edges");
    rdChk(A_PIN, 8'h00, "R4 one edge");
    rdChk(A_PIN, 8'h3C, "R4 two edges");

    // R7 R8 single-bit operations
    bitOp(A_LATCH, 3'd6, 1'b1, 1'b0);
    rdChk(A_LATCH, 8'hE5, "R7 latch set bit6");
    bitOp(A_DIR, 3'd0, 1'b0, 1'b1);
    rdChk(A_DIR, 8'h0E, "R8 dir clear bit0");
    bitOp(A_DIR, 3'd7, 1'b1, 1'b0);
    rdChk(A_DIR, 8'h8E, "R7 dir set bit7");
    bitOp(A_LATCH, 3'd7, 1'b0, 1'b1);
    rdChk(A_LATCH, 8'h65, "R8 latch clear bit7");

    // R9 priority
    addr = A_LATCH; wdata = 8'h11; wrEn = 1'b1; bitSet = 1'b1; bitClr = 1'b1; bitIdx = 3'd7;
    tick();
    wrEn = 1'b0; bitSet = 1'b0; bitClr = 1'b0;
    rdChk(A_LATCH, 8'h11, "R9 write beats strobes");
    bitOp(A_LATCH, 3'd1, 1'b1, 1'b1);
    rdChk(A_LATCH, 8'h13, "R9 set beats clear");

    // R11 unmapped addresses
    busWr(6'h05, 8'hFF);
    bitOp(6'h3F, 3'd2, 1'b0, 1'b1);
    rdChk(A_LATCH, 8'h13, "R11 latch after unmapped write");
    rdChk(A_DIR, 8'h8E, "R11 dir after unmapped write");
    rdChk(6'h05, 8'h00, "R11 unmapped read");
    addr = A_LATCH; rdEn = 1'b0;
    expectOut(SEL_RD, 8'h00, "R11 rdEn low");
    tick();

    // R10 alternate function override
    extMemEn = 1'b1; altOe = 1'b1; altOut = 8'h5A;
    padChk(8'hFF, 8'h5A, 8'hFF, "R10 alt driving");
    altOe = 1'b0; altOut = 8'hC3;
    padChk(8'h00, 8'hC3, 8'hFF, "R10 alt receiving");
    rdChk(A_DIR, 8'h8E, "R10 dir kept");
    extMemEn = 1'b0;
    padChk(8'h8E, 8'h13, 8'h11, "R10 back to normal");

    tick();
    finished = 1'b1;
    report();
  end

endmodule